// File: doc/BRIEF.md
# Ordering-table clear engine

This block is a single-purpose DMA channel that prepares an empty ordering table for a graphics pipeline. Software loads a start address and an entry count, then writes a launch value into the control register. The engine walks memory downward from the start address. At each 32-bit entry it writes the address of the entry just beneath it, so the table forms a linked list that runs toward lower addresses. The lowest entry it writes holds an end-of-list marker in place of a link.

The engine issues one write per cycle on a simple memory port. A write is held until the port signals ready. When the walk ends, the engine clears the launch bits in its control register and raises a one-cycle completion interrupt. A control value other than the launch code still ends the channel and raises the interrupt, but no memory is touched.

The sequencer has four states. IDLE takes register writes and leaves on a control write (IDLE→LAUNCH). LAUNCH decodes the request and goes either to RUN (valid launch code, non-zero count, start above the memory floor) or straight to FINISH. RUN drives one entry at a time and moves RUN→FINISH when the final entry is accepted. FINISH clears the control bits, pulses the interrupt and returns to IDLE (FINISH→IDLE).

Top module: `otc_dma`

## Requirements
- R1: A control write of exactly 0x11000002 while IDLE starts a fill. Any other control value produces no memory write but still completes with the interrupt.
- R2: The count register (select 1, low CNT_W bits) is the number of 32-bit entries to write, used directly. The address and count registers keep their values across runs.
- R3: The first entry is written at the start address and each later one 4 bytes lower. A non-final entry at address A holds (A − 4) masked to 24 bits, with bits 31:24 zero.
- R4: The lowest entry written holds 0x00FFFFFF instead of a link.
- R5: The start address (select 0) has its two low bits cleared on write.
- R6: On completion, control bits 24 and 28 are cleared and all other control bits are kept. The interrupt is high for exactly one cycle per launch.
- R7: No entry is written at or below MEM_BASE. When the walk would reach MEM_BASE, the last entry above it becomes the final entry. A start address at or below MEM_BASE writes nothing.
- R8: A count of zero writes nothing and completes with the interrupt.
- R9: While the memory port is ready, one entry is written per cycle, and the interrupt appears N+2 cycles after the control write for N entries. While mem_ready is low, mem_we stays high with mem_addr and mem_wdata unchanged.
- R10: Register writes made while busy are ignored.
- R11: After reset the engine is idle, the control register reads 0, and mem_we and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 start address, 1 count, 2 control |
| reg_wdata | input | 32 | Register write data |
| ctrl_q | output | 32 | Current control register value |
| busy | output | 1 | High whenever the sequencer is not IDLE |
| irq | output | 1 | One-cycle completion interrupt |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Byte address of the entry being written |
| mem_wdata | output | 32 | Entry value |
| mem_ready | input | 1 | Memory accepts the write this cycle |

## Verification
The assertions assume that the memory port never withdraws a request it has not yet accepted. They also assume that a register write arriving during a run has no influence, and that start addresses lie inside the ADDR_W address space. The stimulus holds mem_ready steady or toggles it in a fixed three-cycle pattern, and changes it only between clock edges. Register writes are issued either while the engine is idle or, in one directed case, deliberately in the middle of a run to show that they are ignored. Start addresses, counts and control codes are chosen so that the floor, zero-count, misaligned and wrong-code paths are each reached.

// File: rtl/otc_pkg.sv
package otc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_RUN,
        ST_FINISH
    } otc_state_t;

    localparam logic [31:0] OTC_GO_CODE   = 32'h1100_0002;
    localparam logic [31:0] OTC_DONE_MASK = 32'h1100_0000;
    localparam logic [23:0] OTC_END_MARK  = 24'hFF_FFFF;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
endpackage

// File: rtl/otc_regs.sv
module otc_regs
    import otc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              accept,
    input  logic              clr_done,
    output logic [ADDR_W-1:0] start_addr,
    output logic [CNT_W-1:0]  entry_cnt,
    output logic [31:0]       ctrl,
    output logic              launch
);
    logic wr_ok;

    assign wr_ok  = reg_we && accept;
    assign launch = wr_ok && (reg_sel == SEL_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_addr <= '0;
            entry_cnt  <= '0;
            ctrl       <= '0;
        end else begin
            if (wr_ok && reg_sel == SEL_START)
                start_addr <= {reg_wdata[ADDR_W-1:2], 2'b00};
            if (wr_ok && reg_sel == SEL_COUNT)
                entry_cnt <= reg_wdata[CNT_W-1:0];
            if (launch)
                ctrl <= reg_wdata;
            else if (clr_done)
                ctrl <= ctrl & ~OTC_DONE_MASK;
        end
    end
endmodule

// File: rtl/otc_fsm.sv
module otc_fsm
    import otc_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter int                CNT_W    = 16,
    parameter logic [ADDR_W-1:0] MEM_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [31:0]       ctrl,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  entry_cnt,
    input  logic              mem_ready,
    output logic              accept,
    output logic              clr_done,
    output logic              busy,
    output logic              irq,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata
);
    localparam logic [ADDR_W:0]   FLOOR = {1'b0, MEM_BASE} + (ADDR_W+1)'(4);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(4);

    otc_state_t        state, state_nx;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    logic              last_entry;
    logic              go_ok;
    logic [31:0]       addr_wide;
    logic [31:0]       link_wide;

    assign last_entry = (remain == CNT_W'(1)) || ({1'b0, cur_addr} <= FLOOR);
    assign go_ok      = (ctrl == OTC_GO_CODE) && (entry_cnt != '0) && (start_addr > MEM_BASE);
    assign addr_wide  = 32'(cur_addr);
    assign link_wide  = addr_wide - 32'd4;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (launch) state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = go_ok ? ST_RUN : ST_FINISH;
            ST_RUN:    if (mem_ready && last_entry) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Walk pointer and remaining count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (state == ST_LAUNCH) begin
            cur_addr <= start_addr;
            remain   <= entry_cnt;
        end else if (state == ST_RUN && mem_ready) begin
            cur_addr <= cur_addr - STEP;
            remain   <= remain - CNT_W'(1);
        end
    end

    // Outputs by state
    always_comb begin
        accept    = 1'b0;
        clr_done  = 1'b0;
        busy      = 1'b1;
        irq       = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_addr;
        mem_wdata = last_entry ? {8'h00, OTC_END_MARK} : {8'h00, link_wide[23:0]};
        unique case (state)
            ST_IDLE: begin
                accept = 1'b1;
                busy   = 1'b0;
            end
            ST_LAUNCH: ;
            ST_RUN:    mem_we = 1'b1;
            ST_FINISH: begin
                irq      = 1'b1;
                clr_done = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/otc_dma.sv
module otc_dma
    import otc_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter int                CNT_W    = 16,
    parameter logic [ADDR_W-1:0] MEM_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       ctrl_q,
    output logic              busy,
    output logic              irq,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready
);
    logic [ADDR_W-1:0] start_addr;
    logic [CNT_W-1:0]  entry_cnt;
    logic              accept;
    logic              clr_done;
    logic              launch;

    otc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .accept    (accept),
        .clr_done  (clr_done),
        .start_addr(start_addr),
        .entry_cnt (entry_cnt),
        .ctrl      (ctrl_q),
        .launch    (launch)
    );

    otc_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MEM_BASE(MEM_BASE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .ctrl      (ctrl_q),
        .start_addr(start_addr),
        .entry_cnt (entry_cnt),
        .mem_ready (mem_ready),
        .accept    (accept),
        .clr_done  (clr_done),
        .busy      (busy),
        .irq       (irq),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );
endmodule

// File: rtl/otc_dma_chk.sv
module otc_dma_chk #(
    parameter int                ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] MEM_BASE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [31:0]       ctrl_q,
    input logic              busy,
    input logic              irq,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ready
);
    p_start_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we && reg_sel == 2'd2));

    p_link_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ready && mem_wdata != 32'h00FF_FFFF)
        |=> (mem_we && mem_addr == $past(mem_addr) - ADDR_W'(4)));

    p_top_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata[31:24] == 8'h00));

    p_end_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ready && mem_wdata == 32'h00FF_FFFF) |=> (irq && !mem_we));

    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_ctrl_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (!ctrl_q[24] && !ctrl_q[28] && !busy));

    p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr > MEM_BASE));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && !irq) |=> $stable(ctrl_q));
endmodule

bind otc_dma otc_dma_chk #(.ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_sel  (reg_sel),
    .ctrl_q   (ctrl_q),
    .busy     (busy),
    .irq      (irq),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ready(mem_ready)
);

// File: tb/otc_dma_test.sv
module otc_dma_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 24;
    localparam int          CNT_W      = 16;
    localparam logic [23:0] BASE       = 24'h00_0100;
    localparam logic [31:0] GO         = 32'h1100_0002;
    localparam logic [31:0] DONE_BITS  = 32'h1100_0000;
    localparam int          NV         = 9;

    // Table: start address, count, control, ready pattern (0 steady, 1 gaps)
    localparam logic [23:0] V_ADDR [NV] = '{24'h00_1000, 24'h00_2003, 24'h00_0110, 24'h00_3000,
                                           24'h00_4000, 24'h00_0100, 24'h80_0010, 24'h00_5000,
                                           24'h00_7000};
    localparam logic [15:0] V_CNT  [NV] = '{16'd4, 16'd3, 16'd10, 16'd0,
                                           16'd5, 16'd3, 16'd2, 16'd1,
                                           16'd4};
    localparam logic [31:0] V_CTRL [NV] = '{GO, GO, GO, GO,
                                           32'h0100_0002, GO, GO, GO,
                                           32'h1100_0003};
    localparam int          V_MODE [NV] = '{0, 1, 0, 0, 0, 0, 1, 1, 0};

    logic              clk, rst_n;
    logic              reg_we;
    logic [1:0]        reg_sel;
    logic [31:0]       reg_wdata;
    logic [31:0]       ctrl_q;
    logic              busy, irq, mem_we, mem_ready;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    int rdy_mode = 0;
    int cyc      = 0;
    int log_n    = 0;
    int irq_cnt  = 0;
    logic [23:0] log_a [32];
    logic [31:0] log_d [32];

    otc_dma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MEM_BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .busy(busy), .irq(irq),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Ready pattern, driven just after each rising edge
    always @(posedge clk) begin
        #1;
        mem_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        cyc++;
    end

    // Record accepted writes and interrupt cycles at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we && mem_ready) begin
                if (log_n < 32) begin
                    log_a[log_n] = mem_addr;
                    log_d[log_n] = mem_wdata;
                end
                log_n++;
            end
            if (irq) irq_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    // Entries expected from the requirements (R1, R2, R5, R7, R8)
    function automatic int exp_n(input logic [23:0] a, input logic [15:0] cnt, input logic [31:0] c);
        logic [23:0] al;
        int room;
        al = {a[23:2], 2'b00};
        if (c != GO) return 0;
        if (al <= BASE) return 0;
        room = int'((al - BASE) >> 2);
        return (int'(cnt) < room) ? int'(cnt) : room;
    endfunction

    task automatic run_case(input logic [23:0] a, input logic [15:0] cnt, input logic [31:0] c,
                            input int mode, input bit prog, input bit meddle);
        int n, lat;
        logic [23:0] a0, ea;
        logic [31:0] ed;
        if (prog) begin
            wr(2'd0, {8'h00, a});
            wr(2'd1, {16'h0, cnt});
        end
        rdy_mode = mode;
        log_n    = 0;
        irq_cnt  = 0;
        wr(2'd2, c);
        if (meddle) begin
            @(negedge clk); #1;
            check(busy == 1'b1, "R10", "busy before ignored writes", 32'(busy), 32'd1);
            wr(2'd1, 32'd1);
            wr(2'd0, 32'h0000_0200);
            wr(2'd2, 32'h0);
        end
        lat = 0;
        while (irq_cnt == 0 && lat < 400) begin
            @(negedge clk); #1;
            lat++;
        end
        check(irq_cnt != 0, "R6", "completion seen", 32'(irq_cnt), 32'd1);
        n  = exp_n(a, cnt, c);
        a0 = {a[23:2], 2'b00};
        if (!meddle && mode == 0)
            check(lat == n + 2, "R9", "cycles to interrupt", 32'(lat), 32'(n + 2));
        repeat (2) @(negedge clk);
        #1;
        check(log_n == n, "R2", "entries written", 32'(log_n), 32'(n));
        for (int k = 0; k < n && k < log_n && k < 32; k++) begin
            ea = a0 - 24'(4 * k);
            ed = (k == n - 1) ? 32'h00FF_FFFF : {8'h00, ea - 24'd4};
            check(log_a[k] == ea, "R3", "entry address", {8'h0, log_a[k]}, {8'h0, ea});
            check(log_d[k] == ed, (k == n - 1) ? "R4" : "R3", "entry value", log_d[k], ed);
        end
        check(irq_cnt == 1, "R6", "interrupt cycles", 32'(irq_cnt), 32'd1);
        check(ctrl_q == (c & ~DONE_BITS), "R6", "control after completion", ctrl_q, c & ~DONE_BITS);
        check(busy == 1'b0, "R6", "idle after completion", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = '0; mem_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R11: reset state
        check(busy == 1'b0,  "R11", "busy after reset", 32'(busy), 32'd0);
        check(irq == 1'b0,   "R11", "irq after reset", 32'(irq), 32'd0);
        check(mem_we == 1'b0, "R11", "mem_we after reset", 32'(mem_we), 32'd0);
        check(ctrl_q == 32'h0, "R11", "control after reset", ctrl_q, 32'h0);

        // Table walk: plain fill, misaligned start (R5), floor cut (R7), zero count (R8),
        // wrong control codes (R1), start at floor (R7), high address masking (R3), single entry (R4)
        for (int i = 0; i < NV; i++)
            run_case(V_ADDR[i], V_CNT[i], V_CTRL[i], V_MODE[i], 1'b1, 1'b0);

        // R10: writes during a run are ignored; the run keeps its programmed values
        run_case(24'h00_6000, 16'd6, GO, 1, 1'b1, 1'b1);
        // R2: registers kept, so a bare relaunch repeats the same table
        run_case(24'h00_6000, 16'd6, GO, 0, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule